// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block is an output-stage clock divider. It counts cycles of an input clock and produces an output clock whose high time and low time are each set by a separate 8-bit count. The output period is the sum of the two counts, so software can pick both the division ratio and the duty cycle. A count of zero stands for the full counter range, which is 256 cycles.

A half-cycle adjust control stretches the high time by half an input cycle. It does this with a register clocked on the falling edge of the input clock. With it, an odd division ratio can still give an even 50% duty cycle. A bypass control routes the input clock directly to the output.

The counts and the half-cycle control may change at any time while the clock runs. The block samples them only on the edge that begins a high phase, so every output period uses one consistent set of values.

Top module: `clkdiv_duty`

## Requirements
- R1: At a rising input edge where rst_n is low, the internal output register clears, and with bypass low clk_out then reads 0. The first rising edge with rst_n high begins a high phase, so clk_out goes to 1 at that edge.
- R2: With odd_sel = 0 and bypass = 0, clk_out is high for exactly H input cycles and then low for exactly L input cycles, where H and L are the captured hi_cnt and lo_cnt. The period is H + L cycles.
- R3: hi_cnt, lo_cnt and odd_sel are sampled only on the rising edge that begins a high phase. A change made after that edge leaves the period already under way unchanged, and the change takes effect from the next period.
- R4: A count field value of 0 is taken as 256 cycles, for both the high count and the low count.
- R5: With odd_sel = 1 captured, the fall of clk_out comes half an input cycle later. The high time is H + 0.5 cycles and the low time is L - 0.5 cycles; for example H = 2 and L = 3 gives 2.5 and 2.5.
- R6: While bypass = 1, clk_out equals clk_in whatever the counts are. When bypass returns to 0, the divided output continues with the current settings.
- R7: The largest nonzero counts work: hi_cnt = lo_cnt = 255 gives a 510-cycle period with 255 cycles high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_cnt | input | 8 | High-phase length in input cycles, 0 meaning 256 |
| lo_cnt | input | 8 | Low-phase length in input cycles, 0 meaning 256 |
| bypass | input | 1 | 1 routes clk_in straight to clk_out |
| odd_sel | input | 1 | 1 extends the high phase by half an input cycle |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench builds the divider with its default counter width of 8 bits. At that width, the zero-means-256 wrap and the 255/255 maximum fit inside a few thousand cycles, so both ends of the count range are measured directly. The bench samples clk_out twice per input cycle, once in each half of clk_in. This lets it count the half-cycle extension of the odd mode and see the bypassed clock, as well as whole-cycle high and low lengths.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
// Package: types shared by the divider modules.
// Assumes: nothing beyond IEEE 1800-2017.
package clkdiv_pkg;
    // Which half of the output period the counter is timing.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;
endpackage

// File: rtl/clkdiv_cfg_latch.sv
`timescale 1ns/1ps
// Module: clkdiv_cfg_latch
// Holds the settings for the current output period. It converts raw count
// fields into effective lengths, with 0 meaning 2**CNT_W.
// Assumes: load is high only on the edge that begins a high phase.
module clkdiv_cfg_latch #(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CNT_W-1:0]   hi_raw,
    input  logic [CNT_W-1:0]   lo_raw,
    input  logic               odd_raw,
    output logic [CNT_W:0]     nxt_hi,
    output logic [CNT_W:0]     cur_hi,
    output logic [CNT_W:0]     cur_lo,
    output logic               cur_odd
);
    localparam int CW = CNT_W + 1;
    localparam logic [CW-1:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};

    logic [CW-1:0] nxt_lo;

    // Map raw fields to effective lengths (zero wraps to full range).
    always_comb begin
        nxt_hi = (hi_raw == '0) ? FULL_RANGE : {1'b0, hi_raw};
        nxt_lo = (lo_raw == '0) ? FULL_RANGE : {1'b0, lo_raw};
    end

    // Capture one consistent setting set at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_hi  <= CW'(1);
            cur_lo  <= CW'(1);
            cur_odd <= 1'b0;
        end else if (load) begin
            cur_hi  <= nxt_hi;
            cur_lo  <= nxt_lo;
            cur_odd <= odd_raw;
        end
    end

    // R3: settings stay frozen between period starts.
    assert_hold_settings_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(cur_hi) && $stable(cur_lo) && $stable(cur_odd)));
endmodule

// File: rtl/clkdiv_phase_ctr.sv
`timescale 1ns/1ps
// Module: clkdiv_phase_ctr
// Times the high and low phases with a down-counter and drives the
// rising-edge output register. It flags the period boundary to the latch.
// Assumes: nxt_hi and cur_lo are nonzero effective lengths.
module clkdiv_phase_ctr
    import clkdiv_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W:0]   nxt_hi,
    input  logic [CNT_W:0]   cur_lo,
    output logic             load,
    output logic             q,
    output logic [CNT_W:0]   remain
);
    localparam int CW = CNT_W + 1;

    phase_t phase;
    logic   last_cycle;

    // Decode the final cycle of a phase and the period boundary.
    always_comb begin
        last_cycle = (remain == CW'(1));
        load       = (phase == PH_LOW) && last_cycle;
    end

    // Advance the phase counter and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_LOW;
            remain <= CW'(1);
            q      <= 1'b0;
        end else if (load) begin
            phase  <= PH_HIGH;
            remain <= nxt_hi;
            q      <= 1'b1;
        end else if (phase == PH_HIGH && last_cycle) begin
            phase  <= PH_LOW;
            remain <= cur_lo;
            q      <= 1'b0;
        end else begin
            remain <= remain - CW'(1);
        end
    end

    // R2: the output only falls after the last high cycle.
    assert_fall_ends_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q) |-> ($past(phase) == PH_HIGH && $past(remain) == CW'(1)));

    // R1: a reset edge always leaves the output register low.
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> !q);
endmodule

// File: rtl/clkdiv_half_ext.sv
`timescale 1ns/1ps
// Module: clkdiv_half_ext
// Copies the output register on the falling clock edge. ORing this copy
// with the original stretches the high phase by half a cycle.
// Assumes: the input is a register clocked on the rising edge of clk.
module clkdiv_half_ext (
    input  logic clk,
    input  logic rst_n,
    input  logic q_in,
    output logic q_late
);
    // Delay the rising-edge output by half a cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) q_late <= 1'b0;
        else        q_late <= q_in;
    end
endmodule

// File: rtl/clkdiv_duty.sv
`timescale 1ns/1ps
// Module: clkdiv_duty (top)
// Divides clk_in by hi_cnt + lo_cnt with a separately set high time. It
// offers an optional half-cycle high extension and a full bypass.
// Assumes: rst_n is synchronous to clk_in; bypass is changed while the
// consumer of clk_out tolerates a clock switch.
module clkdiv_duty #(
    parameter int CNT_W = 8
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    input  logic             bypass,
    input  logic             odd_sel,
    output logic             clk_out
);
    logic           load;
    logic           q;
    logic           q_late;
    logic           cur_odd;
    logic [CNT_W:0] nxt_hi;
    logic [CNT_W:0] cur_hi;
    logic [CNT_W:0] cur_lo;
    logic [CNT_W:0] remain;
    logic           div_clk;

    clkdiv_cfg_latch #(.CNT_W(CNT_W)) u_cfg (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .load    (load),
        .hi_raw  (hi_cnt),
        .lo_raw  (lo_cnt),
        .odd_raw (odd_sel),
        .nxt_hi  (nxt_hi),
        .cur_hi  (cur_hi),
        .cur_lo  (cur_lo),
        .cur_odd (cur_odd)
    );

    clkdiv_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .nxt_hi (nxt_hi),
        .cur_lo (cur_lo),
        .load   (load),
        .q      (q),
        .remain (remain)
    );

    clkdiv_half_ext u_half (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .q_in   (q),
        .q_late (q_late)
    );

    // Pick the divided waveform, then the bypass path.
    always_comb begin
        div_clk = cur_odd ? (q | q_late) : q;
        clk_out = bypass ? clk_in : div_clk;
    end

    // R3: each high phase starts with the length captured for that period.
    assert_rise_loads_hi_R3: assert property (@(posedge clk_in) disable iff (!rst_n)
        $rose(q) |-> (remain == cur_hi));
endmodule

// File: tb/clkdiv_duty_bench.sv
`timescale 1ns/1ps
// Directed bench: each task drives one scenario and checks its results.
module clkdiv_duty_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hi_cnt = 8'd3;
    logic [7:0] lo_cnt = 8'd5;
    logic       bypass = 1'b0;
    logic       odd_sel = 1'b0;
    logic       clk_out;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    logic last_s = 1'b0;
    logic prev_s = 1'b0;
    bit   first_half = 1'b1;
    bit   pending = 1'b0;

    clkdiv_duty u_clkdiv_duty (
        .clk_in (clk), .rst_n (rst_n), .hi_cnt (hi_cnt), .lo_cnt (lo_cnt),
        .bypass (bypass), .odd_sel (odd_sel), .clk_out (clk_out)
    );

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input int act, input int exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance half a clock cycle to the next sample point.
    task automatic get_sample();
        #2.5;
        prev_s = last_s;
        last_s = clk_out;
        first_half = !first_half;
    endtask

    // Count high and low half-cycles from a seen rise up to the next rise.
    task automatic count_after_rise(output int h, output int l);
        h = 1; l = 0;
        for (int i = 0; i < 2000; i++) begin
            get_sample();
            if (last_s && !prev_s) begin
                pending = 1'b1;
                return;
            end
            if (last_s) h++; else l++;
        end
        h = -1; l = -1;
    endtask

    task automatic wait_rise();
        if (pending) begin
            pending = 1'b0;
            return;
        end
        for (int i = 0; i < 2000; i++) begin
            get_sample();
            if (last_s && !prev_s) return;
        end
    endtask

    task automatic measure(output int h, output int l);
        wait_rise();
        count_after_rise(h, l);
    endtask

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 256 : int'(v);
    endfunction

    // Apply settings, skip the period under way, then measure one period.
    task automatic apply_and_check(input logic [7:0] h, input logic [7:0] l,
                                   input logic odd, input string req);
        int mh, ml;
        hi_cnt = h; lo_cnt = l; odd_sel = odd;
        measure(mh, ml);
        measure(mh, ml);
        check(mh, odd ? 2 * eff(h) + 1 : 2 * eff(h), {req, " high half-cycles"});
        check(ml, odd ? 2 * eff(l) - 1 : 2 * eff(l), {req, " low half-cycles"});
    endtask

    // R1: output held low in reset, first edge after release goes high.
    task automatic t_reset();
        int h, l, lows;
        lows = 0;
        rst_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            get_sample();
            if (!last_s) lows++;
        end
        check(lows, 8, "R1 low during reset");
        rst_n = 1'b1;
        get_sample();
        check(int'(last_s), 0, "R1 low before first edge");
        get_sample();
        check(int'(last_s), 1, "R1 high after first edge");
        count_after_rise(h, l);
        check(h, 6, "R2 first period high 3 cycles");
        check(l, 10, "R2 first period low 5 cycles");
    endtask

    // R2: several ratios with the odd control cleared.
    task automatic t_ratios();
        apply_and_check(8'd1, 8'd1, 1'b0, "R2 1/1");
        apply_and_check(8'd4, 8'd1, 1'b0, "R2 4/1");
        apply_and_check(8'd2, 8'd7, 1'b0, "R2 2/7");
    endtask

    // R3: a change after the period start waits for the next period.
    task automatic t_midchange();
        int h, l;
        hi_cnt = 8'd3; lo_cnt = 8'd5; odd_sel = 1'b0;
        measure(h, l);
        wait_rise();
        hi_cnt = 8'd2; lo_cnt = 8'd2; odd_sel = 1'b1;
        count_after_rise(h, l);
        check(h, 6, "R3 current period keeps old high");
        check(l, 10, "R3 current period keeps old low");
        measure(h, l);
        check(h, 5, "R3 next period uses new high");
        check(l, 3, "R3 next period uses new low");
    endtask

    // R4: zero in either field means 256 cycles.
    task automatic t_zero();
        apply_and_check(8'd0, 8'd1, 1'b0, "R4 hi zero");
        apply_and_check(8'd2, 8'd0, 1'b0, "R4 lo zero");
    endtask

    // R5: half-cycle extension of the high phase.
    task automatic t_odd();
        apply_and_check(8'd2, 8'd3, 1'b1, "R5 2/3 odd");
        apply_and_check(8'd1, 8'd2, 1'b1, "R5 1/2 odd");
    endtask

    // R6: bypass passes the input clock, divider resumes afterwards.
    task automatic t_bypass();
        int good;
        good = 0;
        hi_cnt = 8'd3; lo_cnt = 8'd4; odd_sel = 1'b0;
        bypass = 1'b1;
        for (int i = 0; i < 16; i++) begin
            get_sample();
            if (last_s == first_half) good++;
        end
        check(good, 16, "R6 output follows input clock");
        bypass = 1'b0;
        pending = 1'b0;
        apply_and_check(8'd3, 8'd4, 1'b0, "R6 divider resumes");
    endtask

    // R7: largest nonzero counts.
    task automatic t_max();
        apply_and_check(8'd255, 8'd255, 1'b0, "R7 255/255");
    endtask

    initial begin
        @(posedge clk);
        #1.25;
        first_half = 1'b1;
        last_s = clk_out;
        t_reset();
        t_ratios();
        t_midchange();
        t_zero();
        t_odd();
        t_bypass();
        t_max();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule